// File: doc/BRIEF.md
# Simulation Test Status Peripheral

This peripheral lets a self-test program on a CPU report its outcome and end the run. It has a small write-only register window with three 32-bit registers. Writing the control register asks for a shutdown. Writing the pass/fail register emits one result event: a zero value means passed and any other value means failed. Writing the name-pointer register makes the block act as a bus master. It fetches a fixed-length name string, one byte per beat, starting at the written address, and keeps it in a local buffer. Later results carry that buffer.

Software normally writes the name pointer first and then the pass/fail code. A slave access is accepted in the cycle where `bus_req` and `bus_ready` are both high. While the name fetch runs, `bus_ready` is held low. A pass/fail write that arrives during the fetch therefore waits on the bus, and its report carries the newly fetched name. Only full-width writes that land on one of the three registers have an effect. Any other access pulses an error and changes nothing.

Top module: `test_status_unit`

## Requirements
- R1: After reset, `bus_ready` is 1. `shutdown_req`, `result_valid`, `result_fail`, `bus_err`, `fetch_busy` and `mem_req` are 0, and `result_name` and `status_code` are all zeros.
- R2: An accepted full-width write at byte offset 0x0 from the base, with any data, raises `shutdown_req` for exactly one cycle, in the cycle after acceptance.
- R3: An accepted full-width write at offset 0x4 stores the data on `status_code`. In the next cycle it pulses `result_valid` for one cycle, with `result_fail` = 0 when the data is zero and 1 when it is non-zero.
- R4: An accepted full-width write at offset 0x8 starts a fetch. `fetch_busy` and `mem_req` rise in the next cycle and `bus_ready` falls. The block then reads exactly 16 bytes at addresses P, P+1, … P+15, where P is the written data. Each address is held until `mem_valid` takes its byte, whatever the memory latency.
- R5: When the fetch ends, `result_name[8*i+7:8*i]` holds the byte read from P+i for i = 0..14, and the top byte (i = 15) is zero.
- R6: A pass/fail write issued while a fetch runs is stalled (`bus_ready` low) and produces no report until the fetch ends. Its report then carries the new name.
- R7: A full-width write to an address that is not one of the three register offsets pulses `bus_err` for one cycle. This includes misaligned addresses and addresses past the window. No shutdown, no report and no fetch follow, and `status_code` is unchanged.
- R8: A read (`bus_we` = 0), or a write whose byte enables `bus_be` are not all four set, pulses `bus_err` and has no other effect, even at a valid register offset.
- R9: The window starts at parameter `BASE_ADDR` (default 0xFFFF0000) and spans 12 bytes. BASE_ADDR+8 is accepted, while BASE_ADDR-4 and BASE_ADDR+12 are rejected with `bus_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Slave access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_be | input | 4 | Byte enables; all set = full word |
| bus_addr | input | 32 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Access accepted this cycle when high with `bus_req` |
| bus_err | output | 1 | One-cycle pulse after a rejected access |
| mem_req | output | 1 | Master read request, held until a byte is returned |
| mem_addr | output | 32 | Master byte address |
| mem_valid | input | 1 | Memory byte is valid this cycle |
| mem_rdata | input | 8 | Memory byte |
| fetch_busy | output | 1 | Name fetch in progress |
| shutdown_req | output | 1 | One-cycle shutdown request |
| result_valid | output | 1 | One-cycle result event |
| result_fail | output | 1 | Result is a failure (valid with `result_valid`) |
| result_name | output | 128 | Name buffer, byte i at bits 8*i+7:8*i |
| status_code | output | 32 | Last value written to pass/fail |

## Verification
The bench runs the name fetch under zero and multi-cycle memory latency. A design that dropped its address early or counted beats on requests instead of returned bytes would show a wrong beat count or a wrong name. A pass/fail write queued behind a running fetch must stall and then report the fresh name; a design that reported at once would carry the old name. Misaligned, out-of-window, read and partial-enable accesses are sent at valid offsets and around the window edges. A decoder that ignored the low address bits or the byte enables would visibly change `status_code`, pulse a report or start a fetch.

// File: rtl/tsu_pkg.sv
package tsu_pkg;
    typedef enum logic [1:0] {
        SEL_CTRL     = 2'd0,
        SEL_PASSFAIL = 2'd1,
        SEL_NAMEPTR  = 2'd2,
        SEL_NONE     = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/tsu_decode.sv
module tsu_decode
    import tsu_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter int          BE_W      = 4,
    parameter logic [31:0] BASE_ADDR = 32'hFFFF_0000
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [BE_W-1:0]   be,
    output reg_sel_e          sel,
    output logic              bad
);
    localparam int NUM_REGS = 3;

    logic [ADDR_W-1:0]   offset;
    logic [NUM_REGS-1:0] hit;
    logic                full_write;

    assign offset     = addr - ADDR_W'(BASE_ADDR);
    assign full_write = we && (&be);

    // one comparator per register word
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_hit
        assign hit[g] = (offset == ADDR_W'(g * 4));
    end

    always_comb begin
        sel = SEL_NONE;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (hit[i]) sel = reg_sel_e'(2'(i));
        end
        if (!full_write) sel = SEL_NONE;
    end

    assign bad = (sel == SEL_NONE);
endmodule

// File: rtl/tsu_name_fetch.sv
module tsu_name_fetch #(
    parameter int ADDR_W     = 32,
    parameter int NAME_BYTES = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [ADDR_W-1:0]       start_addr,
    output logic                    mem_req,
    output logic [ADDR_W-1:0]       mem_addr,
    input  logic                    mem_valid,
    input  logic [7:0]              mem_rdata,
    output logic                    busy,
    output logic [NAME_BYTES*8-1:0] name
);
    localparam int NAME_W = NAME_BYTES * 8;
    localparam int IDX_W  = $clog2(NAME_BYTES);
    localparam int LAST   = NAME_BYTES - 1;

    typedef struct packed {
        logic              busy;
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] base;
        logic [NAME_W-1:0] name;
    } fetch_st_t;

    fetch_st_t st_d, st_q;
    logic      last_beat;

    assign last_beat = (st_q.idx == IDX_W'(LAST));

    always_comb begin
        st_d = st_q;
        if (!st_q.busy && start) begin
            st_d.busy = 1'b1;
            st_d.idx  = '0;
            st_d.base = start_addr;
        end else if (st_q.busy && mem_valid) begin
            // the final slot is overwritten with a terminator
            st_d.name[{st_q.idx, 3'b000} +: 8] = last_beat ? 8'h00 : mem_rdata;
            if (last_beat) st_d.busy = 1'b0;
            else           st_d.idx  = st_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mem_req  = st_q.busy;
    assign mem_addr = st_q.base + ADDR_W'(st_q.idx);
    assign busy     = st_q.busy;
    assign name     = st_q.name;

    assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

    assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_valid && !last_beat) |=> (mem_req && mem_addr == $past(mem_addr) + 1'b1));

    assert_name_term_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (name[NAME_W-1 -: 8] == 8'h00));
endmodule

// File: rtl/test_status_unit.sv
module test_status_unit
    import tsu_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int          DATA_W     = 32,
    parameter int          NAME_BYTES = 16,
    parameter logic [31:0] BASE_ADDR  = 32'hFFFF_0000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_req,
    input  logic                    bus_we,
    input  logic [DATA_W/8-1:0]     bus_be,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [DATA_W-1:0]       bus_wdata,
    output logic                    bus_ready,
    output logic                    bus_err,
    output logic                    mem_req,
    output logic [ADDR_W-1:0]       mem_addr,
    input  logic                    mem_valid,
    input  logic [7:0]              mem_rdata,
    output logic                    fetch_busy,
    output logic                    shutdown_req,
    output logic                    result_valid,
    output logic                    result_fail,
    output logic [NAME_BYTES*8-1:0] result_name,
    output logic [DATA_W-1:0]       status_code
);
    localparam int BE_W = DATA_W / 8;

    typedef struct packed {
        logic              shutdown;
        logic              rvalid;
        logic              rfail;
        logic              err;
        logic [DATA_W-1:0] code;
    } top_st_t;

    top_st_t  st_d, st_q;
    reg_sel_e sel;
    logic     bad;
    logic     accept;
    logic     fetch_start;

    tsu_decode #(
        .ADDR_W   (ADDR_W),
        .BE_W     (BE_W),
        .BASE_ADDR(BASE_ADDR)
    ) u_decode (
        .addr(bus_addr),
        .we  (bus_we),
        .be  (bus_be),
        .sel (sel),
        .bad (bad)
    );

    assign bus_ready   = !fetch_busy;
    assign accept      = bus_req && bus_ready;
    assign fetch_start = accept && (sel == SEL_NAMEPTR);

    tsu_name_fetch #(
        .ADDR_W    (ADDR_W),
        .NAME_BYTES(NAME_BYTES)
    ) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (fetch_start),
        .start_addr(ADDR_W'(bus_wdata)),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_valid (mem_valid),
        .mem_rdata (mem_rdata),
        .busy      (fetch_busy),
        .name      (result_name)
    );

    always_comb begin
        st_d          = '0;
        st_d.code     = st_q.code;
        if (accept) begin
            if (bad) begin
                st_d.err = 1'b1;
            end else begin
                case (sel)
                    SEL_CTRL:     st_d.shutdown = 1'b1;
                    SEL_PASSFAIL: begin
                        st_d.code   = bus_wdata;
                        st_d.rvalid = 1'b1;
                        st_d.rfail  = |bus_wdata;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign shutdown_req = st_q.shutdown;
    assign result_valid = st_q.rvalid;
    assign result_fail  = st_q.rfail;
    assign bus_err      = st_q.err;
    assign status_code  = st_q.code;

    assert_shutdown_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shutdown_req) |-> $past(bus_req && bus_ready && bus_we));

    assert_report_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> !fetch_busy);

    assert_err_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (!shutdown_req && !result_valid));

    assert_code_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $stable(status_code));
endmodule

// File: tb/sim_test_status_unit.sv
`timescale 1ns/1ps
module sim_test_status_unit;
    localparam logic [31:0] BASE = 32'hFFFF_0000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_req = 1'b0, bus_we = 1'b0;
    logic [3:0]   bus_be = 4'h0;
    logic [31:0]  bus_addr = '0, bus_wdata = '0;
    logic         bus_ready, bus_err, mem_req, mem_valid = 1'b0;
    logic [31:0]  mem_addr;
    logic [7:0]   mem_rdata = 8'h00;
    logic         fetch_busy, shutdown_req, result_valid, result_fail;
    logic [127:0] result_name;
    logic [31:0]  status_code;

    int n_checks = 0, n_fail = 0;
    int lat = 0, wait_cnt = 0;
    int beat_cnt = 0, bad_beats = 0;
    logic [31:0] exp_next = '0;

    always #2 clk = ~clk;

    test_status_unit u0 (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we), .bus_be(bus_be),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_err(bus_err),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
        .fetch_busy(fetch_busy), .shutdown_req(shutdown_req), .result_valid(result_valid),
        .result_fail(result_fail), .result_name(result_name), .status_code(status_code)
    );

    function automatic logic [7:0] mem_byte(input logic [31:0] a);
        return a[7:0] ^ 8'h5A ^ a[15:8];
    endfunction

    function automatic logic [127:0] exp_name(input logic [31:0] p);
        logic [127:0] n = '0;
        for (int i = 0; i < 15; i++) n[8*i +: 8] = mem_byte(p + 32'(i));
        return n;
    endfunction

    // memory model with programmable latency, also records beat addresses
    always @(negedge clk) begin
        if (mem_req) begin
            if (wait_cnt >= lat) begin
                mem_valid = 1'b1;
                mem_rdata = mem_byte(mem_addr);
                if (mem_addr != exp_next) bad_beats++;
                exp_next = mem_addr + 1;
                beat_cnt++;
                wait_cnt = 0;
            end else begin
                mem_valid = 1'b0;
                wait_cnt++;
            end
        end else begin
            mem_valid = 1'b0;
            wait_cnt  = 0;
        end
    end

    task automatic check(input logic ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_access(input logic [31:0] a, input logic [31:0] d, input logic we,
                              input logic [3:0] be, output int stalls, output int early);
        stalls = 0; early = 0;
        bus_req = 1'b1; bus_addr = a; bus_wdata = d; bus_we = we; bus_be = be;
        while (!bus_ready) begin
            @(negedge clk);
            stalls++;
            if (result_valid) early++;
        end
        @(posedge clk);
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0; bus_be = 4'h0;
    endtask

    task automatic wait_fetch();
        while (fetch_busy) @(negedge clk);
    endtask

    task automatic t_reset();
        check(bus_ready === 1'b1, "R1 ready", 128'(bus_ready), 1);
        check({shutdown_req, result_valid, result_fail, bus_err, fetch_busy, mem_req} === 6'b0,
              "R1 strobes", 128'({shutdown_req, result_valid, result_fail, bus_err, fetch_busy, mem_req}), 0);
        check(result_name === '0, "R1 name", result_name, 0);
        check(status_code === '0, "R1 code", 128'(status_code), 0);
    endtask

    task automatic t_shutdown();
        int s, e;
        bus_access(BASE, 32'h0, 1'b1, 4'hF, s, e);
        check(shutdown_req === 1'b1, "R2 pulse data0", 128'(shutdown_req), 1);
        @(negedge clk);
        check(shutdown_req === 1'b0, "R2 single cycle", 128'(shutdown_req), 0);
        bus_access(BASE, 32'hFFFF_FFFF, 1'b1, 4'hF, s, e);
        check(shutdown_req === 1'b1 && result_valid === 1'b0, "R2 pulse dataF", 128'(shutdown_req), 1);
        @(negedge clk);
        check(shutdown_req === 1'b0, "R2 single cycle 2", 128'(shutdown_req), 0);
    endtask

    task automatic t_passfail();
        int s, e;
        bus_access(BASE + 4, 32'h0, 1'b1, 4'hF, s, e);
        check(result_valid === 1'b1 && result_fail === 1'b0, "R3 pass",
              128'({result_valid, result_fail}), 128'(2'b10));
        @(negedge clk);
        check(result_valid === 1'b0, "R3 single cycle", 128'(result_valid), 0);
        bus_access(BASE + 4, 32'h0000_0100, 1'b1, 4'hF, s, e);
        check(result_valid === 1'b1 && result_fail === 1'b1, "R3 fail",
              128'({result_valid, result_fail}), 128'(2'b11));
        check(status_code === 32'h0000_0100, "R3 code", 128'(status_code), 128'(32'h100));
    endtask

    task automatic t_fetch(input logic [31:0] p, input int l);
        int s, e;
        lat = l; beat_cnt = 0; bad_beats = 0; exp_next = p;
        bus_access(BASE + 8, p, 1'b1, 4'hF, s, e);
        check(fetch_busy === 1'b1 && mem_req === 1'b1 && bus_ready === 1'b0, "R4 fetch start",
              128'({fetch_busy, mem_req, bus_ready}), 128'(3'b110));
        wait_fetch();
        check(beat_cnt == 16, "R4 beat count", 128'(beat_cnt), 16);
        check(bad_beats == 0, "R4 beat addresses", 128'(bad_beats), 0);
        check(result_name === exp_name(p), "R5 name content", result_name, exp_name(p));
        check(result_name[127:120] === 8'h00, "R5 terminator", 128'(result_name[127:120]), 0);
        lat = 0;
    endtask

    task automatic t_stall();
        int s, e;
        logic [31:0] p = 32'h0000_4A30;
        lat = 1; beat_cnt = 0; bad_beats = 0; exp_next = p;
        bus_access(BASE + 8, p, 1'b1, 4'hF, s, e);
        bus_access(BASE + 4, 32'h0, 1'b1, 4'hF, s, e);
        check(s > 0, "R6 stalled during fetch", 128'(s), 1);
        check(e == 0, "R6 no early report", 128'(e), 0);
        check(result_valid === 1'b1 && result_fail === 1'b0, "R6 report after fetch",
              128'({result_valid, result_fail}), 128'(2'b10));
        check(result_name === exp_name(p), "R6 new name", result_name, exp_name(p));
        lat = 0;
    endtask

    task automatic t_bad_addr();
        int s, e;
        logic [127:0] nm;
        bus_access(BASE + 4, 32'h55, 1'b1, 4'hF, s, e);
        nm = result_name;
        bus_access(BASE + 32'h10, 32'h99, 1'b1, 4'hF, s, e);
        check(bus_err === 1'b1 && result_valid === 1'b0 && shutdown_req === 1'b0, "R7 far addr",
              128'({bus_err, result_valid, shutdown_req}), 128'(3'b100));
        @(negedge clk);
        check(bus_err === 1'b0 && status_code === 32'h55 && fetch_busy === 1'b0, "R7 no change",
              128'(status_code), 128'(32'h55));
        bus_access(BASE + 6, 32'h0000_2000, 1'b1, 4'hF, s, e);
        check(bus_err === 1'b1 && result_valid === 1'b0, "R7 misaligned", 128'(bus_err), 1);
        @(negedge clk);
        check(fetch_busy === 1'b0 && result_name === nm && status_code === 32'h55, "R7 state kept",
              result_name, nm);
    endtask

    task automatic t_bad_access();
        int s, e;
        bus_access(BASE + 8, 32'h0000_3000, 1'b0, 4'hF, s, e);
        check(bus_err === 1'b1, "R8 read rejected", 128'(bus_err), 1);
        @(negedge clk);
        check(fetch_busy === 1'b0 && mem_req === 1'b0, "R8 read no fetch", 128'(fetch_busy), 0);
        bus_access(BASE + 4, 32'h77, 1'b1, 4'h3, s, e);
        check(bus_err === 1'b1 && result_valid === 1'b0, "R8 partial rejected",
              128'({bus_err, result_valid}), 128'(2'b10));
        check(status_code === 32'h55, "R8 code kept", 128'(status_code), 128'(32'h55));
        bus_access(BASE, 32'h1, 1'b1, 4'h7, s, e);
        check(bus_err === 1'b1 && shutdown_req === 1'b0, "R8 partial ctrl",
              128'({bus_err, shutdown_req}), 128'(2'b10));
    endtask

    task automatic t_window();
        int s, e;
        bus_access(BASE - 4, 32'h1, 1'b1, 4'hF, s, e);
        check(bus_err === 1'b1 && result_valid === 1'b0 && shutdown_req === 1'b0, "R9 below base",
              128'(bus_err), 1);
        bus_access(BASE + 12, 32'h1, 1'b1, 4'hF, s, e);
        check(bus_err === 1'b1 && fetch_busy === 1'b0, "R9 past end", 128'(bus_err), 1);
        bus_access(BASE + 8, 32'h0000_0010, 1'b1, 4'hF, s, e);
        check(bus_err === 1'b0 && fetch_busy === 1'b1, "R9 last word accepted",
              128'({bus_err, fetch_busy}), 128'(2'b01));
        wait_fetch();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_shutdown();
        t_passfail();
        t_fetch(32'h0000_1000, 0);
        t_fetch(32'h8000_00F8, 2);
        t_stall();
        t_bad_addr();
        t_bad_access();
        t_window();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule